// File: doc/BRIEF.md
# TDM Time Slot Assigner

This block serves one side of a serial time-division-multiplexed voice interface. The interface carries a bit clock, a frame sync that marks each 8 kHz frame, one serial input line and one serial output line. The block counts bits from the frame sync and splits the frame into slots. During one programmed input slot it shifts in the serial data and hands the word to a processing core as a parallel sample. During one programmed output slot it takes a result word from the core and shifts it out. At every other time its output driver is disabled.

Slot width follows the coding direction. PCM samples use 8-bit slots and compressed samples use 4-bit slots, so compressing reads 8-bit slots and writes 4-bit slots, and expanding does the reverse. A pass-through mode copies the captured word straight to the output without the core. An idle mode keeps the output released. A frame sync held for two bit periods marks a signaling frame: in such a frame a 32 kbps rate request is reported to the core as 24 kbps, which frees the output LSB for signaling.

The bit clock, frame sync and data lines are sampled in the system clock domain. That clock must run at least four times faster than the bit clock.

Top module: `tdm_slot_assigner`

## Requirements
- R1: Bit 0 of a frame starts at the first bit-clock rising edge at which the frame sync is low after it was high at the previous rising edge. Later rising edges count up. Until the first frame sync after reset, no slot matches.
- R2: Input bits are sampled on bit-clock falling edges inside the programmed input slot, first bit as MSB. The slot is 8 bits when `cfg_compress`=1 and 4 bits when it is 0. After the last bit, `smp_valid` is high for exactly one clock with the word on `smp_data`, and a 4-bit word sits in bits [3:0] with zeros above.
- R3: Inside the programmed output slot, `tdm_doe` is high and `tdm_dout` takes a new bit at each bit-clock rising edge, MSB first. The word is latched from `res_data` at the first bit of the slot, using `res_data[3:0]` for a 4-bit slot. Outside the slot `tdm_doe` is low, and `tdm_dout` changes only on a clock where a bit-clock rise is seen.
- R4: A frame holds 256 bits, which gives 32 wide slots (0 to 31) or 64 narrow slots (0 to 63). A slot number past the available count never matches, so no strobe is raised and the output is never enabled for it.
- R5: In bypass (`cfg_bypass`=1, `cfg_idle`=0), both sides use 8-bit slots when `cfg_compress`=1 and 4-bit slots when it is 0. The output slot sends the last word captured from the input slot, and `smp_valid` stays low.
- R6: While `cfg_idle`=1, `tdm_doe` is low from the next clock on and `smp_valid` stays low.
- R7: A frame whose sync is high at two or more consecutive bit-clock rising edges is a signaling frame. Rate codes are 00 = 32 kbps, 01 = 24 kbps, 10 = 16 kbps. In a signaling frame a `cfg_rate` of 00 is reported on `smp_rate` as 01, and every other code passes through unchanged.
- R8: `smp_rate` is the effective rate taken at the moment of each strobe. A rate change therefore applies to the next sample with no reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tdm_bclk | input | 1 | Serial bit clock |
| tdm_fsync | input | 1 | Frame sync, one or two bit periods wide |
| tdm_din | input | 1 | Serial input data |
| tdm_dout | output | 1 | Serial output data |
| tdm_doe | output | 1 | Output driver enable (low = released) |
| cfg_compress | input | 1 | 1 = compress (8-bit in, 4-bit out), 0 = expand |
| cfg_bypass | input | 1 | Pass-through without the core |
| cfg_idle | input | 1 | Channel idle, output released |
| cfg_rate | input | 2 | Requested rate code |
| cfg_in_slot | input | 6 | Input slot number |
| cfg_out_slot | input | 6 | Output slot number |
| res_data | input | 8 | Result word from the core |
| smp_valid | output | 1 | One-clock strobe for a captured sample |
| smp_data | output | 8 | Captured sample word |
| smp_rate | output | 2 | Effective rate for this sample |

## Verification
The frame restart and the first bit of output slot 0 fall on the same bit-clock rise. That rise must reset the counter, load the result word and drive its MSB, all at once. The bench provokes this with output slot 0 and input slot 0. It does so after both single-width and double-width syncs, and after frames in which the counter sat saturated. It judges the result by comparing every observed output bit and enable against a bit map built from the slot arithmetic. The rate decision at a strobe is judged by checking `smp_rate` in signaling frames against both the 32 kbps code and the other codes.

// File: rtl/tsa_pkg.sv
package tsa_pkg;
  typedef enum logic [1:0] {
    RATE_32K = 2'b00,
    RATE_24K = 2'b01,
    RATE_16K = 2'b10,
    RATE_RSV = 2'b11
  } rate_e;
endpackage

// File: rtl/tsa_frame_timer.sv
module tsa_frame_timer #(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bclk,
  input  logic             fsync,
  output logic             bclk_rise,
  output logic             bclk_fall,
  output logic [CNT_W-1:0] bit_cnt,
  output logic [CNT_W-1:0] bit_cnt_nxt,
  output logic             sig_frame
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic       bclk_q;
  logic       fs_q, fs_q_d;
  logic [1:0] fs_len, fs_len_d;
  logic       sig_d;

  assign bclk_rise = bclk & ~bclk_q;
  assign bclk_fall = ~bclk & bclk_q;

  always_comb begin
    bit_cnt_nxt = bit_cnt;
    fs_q_d      = fs_q;
    fs_len_d    = fs_len;
    sig_d       = sig_frame;
    if (bclk_rise) begin
      fs_q_d = fsync;
      if (fsync) begin
        fs_len_d = fs_q ? ((fs_len == 2'd3) ? 2'd3 : fs_len + 2'd1) : 2'd1;
      end
      if (!fsync && fs_q) begin
        bit_cnt_nxt = '0;
        sig_d       = (fs_len >= 2'd2);
      end else if (bit_cnt != CNT_MAX) begin
        bit_cnt_nxt = bit_cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_q    <= 1'b0;
      fs_q      <= 1'b0;
      fs_len    <= 2'd0;
      sig_frame <= 1'b0;
      bit_cnt   <= CNT_MAX;
    end else begin
      bclk_q    <= bclk;
      fs_q      <= fs_q_d;
      fs_len    <= fs_len_d;
      sig_frame <= sig_d;
      bit_cnt   <= bit_cnt_nxt;
    end
  end
endmodule

// File: rtl/tsa_slot_match.sv
module tsa_slot_match #(
  parameter int CNT_W      = 9,
  parameter int SLOT_W     = 6,
  parameter int WIDE_W     = 8,
  parameter int NARROW_W   = 4,
  parameter int FRAME_BITS = 256
) (
  input  logic [CNT_W-1:0]  cnt,
  input  logic [SLOT_W-1:0] slot,
  input  logic              wide,
  output logic              hit,
  output logic              first,
  output logic              last
);
  localparam int WSH = $clog2(WIDE_W);
  localparam int NSH = $clog2(NARROW_W);

  logic [CNT_W-1:0] idx;
  logic [CNT_W-1:0] pos;

  always_comb begin
    idx   = wide ? (cnt >> WSH) : (cnt >> NSH);
    pos   = wide ? (cnt & CNT_W'(WIDE_W - 1)) : (cnt & CNT_W'(NARROW_W - 1));
    hit   = (cnt < CNT_W'(FRAME_BITS)) && (idx == CNT_W'(slot));
    first = (pos == '0);
    last  = wide ? (pos == CNT_W'(WIDE_W - 1)) : (pos == CNT_W'(NARROW_W - 1));
  end
endmodule

// File: rtl/tsa_rx.sv
module tsa_rx #(
  parameter int CNT_W      = 9,
  parameter int SLOT_W     = 6,
  parameter int WIDE_W     = 8,
  parameter int NARROW_W   = 4,
  parameter int FRAME_BITS = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bclk_fall,
  input  logic [CNT_W-1:0]  bit_cnt,
  input  logic              din,
  input  logic [SLOT_W-1:0] in_slot,
  input  logic              wide,
  input  logic              pass_thru,
  input  logic              idle,
  input  logic [1:0]        rate_eff,
  output logic              smp_valid,
  output logic [WIDE_W-1:0] smp_data,
  output logic [1:0]        smp_rate,
  output logic [WIDE_W-1:0] byp_word
);
  logic              hit, first, last;
  logic [WIDE_W-1:0] sh, sh_d, shifted, word;
  logic              vld_d;
  logic [WIDE_W-1:0] data_d, byp_d;
  logic [1:0]        rate_d;

  tsa_slot_match #(
    .CNT_W(CNT_W), .SLOT_W(SLOT_W), .WIDE_W(WIDE_W),
    .NARROW_W(NARROW_W), .FRAME_BITS(FRAME_BITS)
  ) u_match (
    .cnt(bit_cnt), .slot(in_slot), .wide(wide),
    .hit(hit), .first(first), .last(last)
  );

  always_comb begin
    shifted = {sh[WIDE_W-2:0], din};
    word    = wide ? shifted : WIDE_W'(shifted[NARROW_W-1:0]);
    sh_d    = sh;
    vld_d   = 1'b0;
    data_d  = smp_data;
    rate_d  = smp_rate;
    byp_d   = byp_word;
    if (bclk_fall && hit) begin
      sh_d = first ? WIDE_W'(din) : shifted;
      if (last) begin
        if (pass_thru) begin
          byp_d = word;
        end else if (!idle) begin
          vld_d  = 1'b1;
          data_d = word;
          rate_d = rate_eff;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh        <= '0;
      smp_valid <= 1'b0;
      smp_data  <= '0;
      smp_rate  <= '0;
      byp_word  <= '0;
    end else begin
      sh        <= sh_d;
      smp_valid <= vld_d;
      smp_data  <= data_d;
      smp_rate  <= rate_d;
      byp_word  <= byp_d;
    end
  end
endmodule

// File: rtl/tsa_tx.sv
module tsa_tx #(
  parameter int CNT_W      = 9,
  parameter int SLOT_W     = 6,
  parameter int WIDE_W     = 8,
  parameter int NARROW_W   = 4,
  parameter int FRAME_BITS = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bclk_rise,
  input  logic [CNT_W-1:0]  cnt_nxt,
  input  logic [SLOT_W-1:0] out_slot,
  input  logic              wide,
  input  logic              idle,
  input  logic [WIDE_W-1:0] src_word,
  output logic              dout,
  output logic              doe
);
  logic              hit, first, last;
  logic [WIDE_W-1:0] aligned, sh, sh_d;
  logic              dout_d, doe_d;

  tsa_slot_match #(
    .CNT_W(CNT_W), .SLOT_W(SLOT_W), .WIDE_W(WIDE_W),
    .NARROW_W(NARROW_W), .FRAME_BITS(FRAME_BITS)
  ) u_match (
    .cnt(cnt_nxt), .slot(out_slot), .wide(wide),
    .hit(hit), .first(first), .last(last)
  );

  always_comb begin
    aligned = wide ? src_word
                   : {src_word[NARROW_W-1:0], {(WIDE_W-NARROW_W){1'b0}}};
    sh_d    = sh;
    dout_d  = dout;
    doe_d   = doe;
    if (bclk_rise) begin
      doe_d = hit;
      if (hit) begin
        if (first) begin
          dout_d = aligned[WIDE_W-1];
          sh_d   = aligned << 1;
        end else begin
          dout_d = sh[WIDE_W-1];
          sh_d   = sh << 1;
        end
      end
    end
    if (idle) begin
      doe_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh   <= '0;
      dout <= 1'b0;
      doe  <= 1'b0;
    end else begin
      sh   <= sh_d;
      dout <= dout_d;
      doe  <= doe_d;
    end
  end

  logic unused_last;
  assign unused_last = last;
endmodule

// File: rtl/tdm_slot_assigner.sv
module tdm_slot_assigner #(
  parameter int DATA_W    = 8,
  parameter int NUM_SLOTS = 64
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         tdm_bclk,
  input  logic                         tdm_fsync,
  input  logic                         tdm_din,
  output logic                         tdm_dout,
  output logic                         tdm_doe,
  input  logic                         cfg_compress,
  input  logic                         cfg_bypass,
  input  logic                         cfg_idle,
  input  logic [1:0]                   cfg_rate,
  input  logic [$clog2(NUM_SLOTS)-1:0] cfg_in_slot,
  input  logic [$clog2(NUM_SLOTS)-1:0] cfg_out_slot,
  input  logic [DATA_W-1:0]            res_data,
  output logic                         smp_valid,
  output logic [DATA_W-1:0]            smp_data,
  output logic [1:0]                   smp_rate
);
  import tsa_pkg::*;

  localparam int NARROW_W   = DATA_W / 2;
  localparam int FRAME_BITS = NUM_SLOTS * NARROW_W;
  localparam int CNT_W      = $clog2(FRAME_BITS) + 1;
  localparam int SLOT_W     = $clog2(NUM_SLOTS);

  logic             rst_s0, rst_s1;
  logic             bclk_rise, bclk_fall, sig_frame;
  logic [CNT_W-1:0] bit_cnt, bit_cnt_nxt;
  logic             pass_thru, out_wide;
  rate_e            req_rate, eff_rate;
  logic [DATA_W-1:0] byp_word, src_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s0 <= 1'b0;
      rst_s1 <= 1'b0;
    end else begin
      rst_s0 <= 1'b1;
      rst_s1 <= rst_s0;
    end
  end

  always_comb begin
    pass_thru = cfg_bypass & ~cfg_idle;
    out_wide  = pass_thru ? cfg_compress : ~cfg_compress;
    req_rate  = rate_e'(cfg_rate);
    eff_rate  = (sig_frame && req_rate == RATE_32K) ? RATE_24K : req_rate;
    src_word  = pass_thru ? byp_word : res_data;
  end

  tsa_frame_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_s1), .bclk(tdm_bclk), .fsync(tdm_fsync),
    .bclk_rise(bclk_rise), .bclk_fall(bclk_fall),
    .bit_cnt(bit_cnt), .bit_cnt_nxt(bit_cnt_nxt), .sig_frame(sig_frame)
  );

  tsa_rx #(
    .CNT_W(CNT_W), .SLOT_W(SLOT_W), .WIDE_W(DATA_W),
    .NARROW_W(NARROW_W), .FRAME_BITS(FRAME_BITS)
  ) u_rx (
    .clk(clk), .rst_n(rst_s1), .bclk_fall(bclk_fall), .bit_cnt(bit_cnt),
    .din(tdm_din), .in_slot(cfg_in_slot), .wide(cfg_compress),
    .pass_thru(pass_thru), .idle(cfg_idle), .rate_eff(eff_rate),
    .smp_valid(smp_valid), .smp_data(smp_data), .smp_rate(smp_rate),
    .byp_word(byp_word)
  );

  tsa_tx #(
    .CNT_W(CNT_W), .SLOT_W(SLOT_W), .WIDE_W(DATA_W),
    .NARROW_W(NARROW_W), .FRAME_BITS(FRAME_BITS)
  ) u_tx (
    .clk(clk), .rst_n(rst_s1), .bclk_rise(bclk_rise), .cnt_nxt(bit_cnt_nxt),
    .out_slot(cfg_out_slot), .wide(out_wide), .idle(cfg_idle),
    .src_word(src_word), .dout(tdm_dout), .doe(tdm_doe)
  );
endmodule

// File: rtl/tsa_checker.sv
module tsa_checker (
  input logic clk,
  input logic rst_n,
  input logic tdm_bclk,
  input logic tdm_dout,
  input logic tdm_doe,
  input logic cfg_bypass,
  input logic cfg_idle,
  input logic smp_valid
);
  // R6: an idle channel releases its output on the following clock
  assert_idle_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_idle |=> !tdm_doe);

  // R6: no sample strobe for an idle channel
  assert_idle_no_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_idle |=> !smp_valid);

  // R5: pass-through never hands a sample to the core
  assert_bypass_no_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_bypass && !cfg_idle) |=> !smp_valid);

  // R2: the sample strobe lasts one clock
  assert_strobe_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |=> !smp_valid);

  // R3: serial output moves only where a bit-clock rise is seen
  assert_dout_on_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(tdm_bclk && !$past(tdm_bclk)) |=> $stable(tdm_dout));
endmodule

bind tdm_slot_assigner tsa_checker u_chk (
  .clk(clk), .rst_n(rst_n), .tdm_bclk(tdm_bclk), .tdm_dout(tdm_dout),
  .tdm_doe(tdm_doe), .cfg_bypass(cfg_bypass), .cfg_idle(cfg_idle),
  .smp_valid(smp_valid)
);

// File: tb/tdm_slot_assigner_tb.sv
module tdm_slot_assigner_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NBITS      = 256;
  localparam int NOBS       = 258;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tdm_bclk, tdm_fsync, tdm_din;
  logic       tdm_dout, tdm_doe;
  logic       cfg_compress, cfg_bypass, cfg_idle;
  logic [1:0] cfg_rate;
  logic [5:0] cfg_in_slot, cfg_out_slot;
  logic [7:0] res_data;
  logic       smp_valid;
  logic [7:0] smp_data;
  logic [1:0] smp_rate;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  logic in_bits [NBITS];
  logic oe_obs  [NOBS];
  logic do_obs  [NOBS];
  int         strobe_cnt;
  logic [7:0] strobe_data;
  logic [1:0] strobe_rate;

  always #(CLK_PERIOD/2) clk = ~clk;

  tdm_slot_assigner u_dut (
    .clk(clk), .rst_n(rst_n), .tdm_bclk(tdm_bclk), .tdm_fsync(tdm_fsync),
    .tdm_din(tdm_din), .tdm_dout(tdm_dout), .tdm_doe(tdm_doe),
    .cfg_compress(cfg_compress), .cfg_bypass(cfg_bypass), .cfg_idle(cfg_idle),
    .cfg_rate(cfg_rate), .cfg_in_slot(cfg_in_slot), .cfg_out_slot(cfg_out_slot),
    .res_data(res_data), .smp_valid(smp_valid), .smp_data(smp_data),
    .smp_rate(smp_rate)
  );

  always @(negedge clk) begin
    if (smp_valid) begin
      strobe_cnt  <= strobe_cnt + 1;
      strobe_data <= smp_data;
      strobe_rate <= smp_rate;
    end
  end

  task automatic check(input bit ok, input string what, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  function automatic int in_width(input logic comp);
    return comp ? 8 : 4;
  endfunction

  function automatic int out_width(input logic comp, input logic byp, input logic idl);
    if (byp && !idl) return comp ? 8 : 4;
    return comp ? 4 : 8;
  endfunction

  function automatic logic [7:0] exp_in_word(input int slot, input int w);
    logic [7:0] v = '0;
    for (int b = 0; b < w; b++) v[w-1-b] = in_bits[slot*w + b];
    return v;
  endfunction

  function automatic logic [1:0] exp_rate(input logic [1:0] r, input bit sig);
    return (sig && r == 2'b00) ? 2'b01 : r;
  endfunction

  task automatic bit_period(input logic fs, input logic d, input int idx);
    @(negedge clk);
    tdm_bclk = 1'b1; tdm_fsync = fs; tdm_din = d;
    repeat (3) @(negedge clk);
    if (idx >= 0) begin
      oe_obs[idx] = tdm_doe;
      do_obs[idx] = tdm_dout;
    end
    @(negedge clk);
    tdm_bclk = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic run_frame(input bit sig);
    int iw, ow, exp_n, mism;
    bit in_ok, out_ok, byp;
    logic [7:0] word, oword;
    for (int k = 0; k < NBITS; k++) in_bits[k] = 1'($urandom);
    @(negedge clk);
    strobe_cnt = 0;
    bit_period(1'b1, 1'b0, -1);
    if (sig) bit_period(1'b1, 1'b0, -1);
    for (int k = 0; k < NOBS; k++)
      bit_period(1'b0, (k < NBITS) ? in_bits[k] : 1'b0, k);
    repeat (2) @(negedge clk);

    byp    = cfg_bypass && !cfg_idle;
    iw     = in_width(cfg_compress);
    ow     = out_width(cfg_compress, cfg_bypass, cfg_idle);
    in_ok  = (int'(cfg_in_slot) * iw + iw) <= NBITS;
    out_ok = (int'(cfg_out_slot) * ow + ow) <= NBITS;
    word   = exp_in_word(int'(cfg_in_slot), iw);
    exp_n  = (!cfg_idle && !byp && in_ok) ? 1 : 0;
    check(strobe_cnt == exp_n, "R2 R4 R5 R6 strobe count", strobe_cnt, exp_n);
    if (exp_n == 1) begin
      check(strobe_data == word, "R1 R2 sample word", int'(strobe_data), int'(word));
      check(strobe_rate == exp_rate(cfg_rate, sig), "R7 R8 sample rate",
            int'(strobe_rate), int'(exp_rate(cfg_rate, sig)));
    end
    oword = byp ? word : res_data;
    if (ow == 4) oword = {4'b0, oword[3:0]};
    mism = 0;
    for (int k = 0; k < NOBS; k++) begin
      bit e_oe;
      e_oe = !cfg_idle && out_ok && k < NBITS && (k / ow) == int'(cfg_out_slot);
      if (oe_obs[k] !== e_oe) mism++;
      else if (e_oe && do_obs[k] !== oword[ow - 1 - (k % ow)]) mism++;
    end
    check(mism == 0, "R1 R3 R4 R5 R6 output bit mismatches", mism, 0);
  endtask

  task automatic set_cfg(input logic comp, input logic byp, input logic idl,
                         input logic [1:0] rate, input int islot, input int oslot);
    @(negedge clk);
    cfg_compress = comp; cfg_bypass = byp; cfg_idle = idl; cfg_rate = rate;
    cfg_in_slot = 6'(islot); cfg_out_slot = 6'(oslot);
    res_data = 8'($urandom);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5A17));
    rst_n = 1'b0; tdm_bclk = 1'b0; tdm_fsync = 1'b0; tdm_din = 1'b0;
    cfg_compress = 1'b1; cfg_bypass = 1'b0; cfg_idle = 1'b0; cfg_rate = 2'b00;
    cfg_in_slot = '0; cfg_out_slot = '0; res_data = '0; strobe_cnt = 0;
    strobe_data = '0; strobe_rate = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(tdm_doe == 1'b0, "R3 reset doe", int'(tdm_doe), 0);
    check(smp_valid == 1'b0, "R2 reset smp_valid", int'(smp_valid), 0);
    // R1: bit clock running with no frame sync: nothing matches
    for (int k = 0; k < 40; k++) bit_period(1'b0, 1'b1, k);
    begin
      int n = 0;
      for (int k = 0; k < 40; k++) if (oe_obs[k]) n++;
      check(n == 0 && strobe_cnt == 0, "R1 no slot before first sync", n + strobe_cnt, 0);
    end

    set_cfg(1, 0, 0, 2'b00, 0, 0);   run_frame(0);  // R1 R2 R3 R8 slot 0
    set_cfg(0, 0, 0, 2'b10, 63, 31); run_frame(0);  // R4 top slots
    set_cfg(1, 0, 0, 2'b00, 31, 63); run_frame(1);  // R7 32k becomes 24k
    set_cfg(1, 0, 0, 2'b10, 2, 0);   run_frame(1);  // R7 16k unchanged, out slot 0
    set_cfg(1, 0, 0, 2'b00, 0, 0);   run_frame(0);  // R7 back to normal frame
    set_cfg(1, 0, 0, 2'b01, 40, 5);  run_frame(0);  // R4 wide slot out of range
    set_cfg(0, 0, 0, 2'b00, 7, 32);  run_frame(0);  // R4 wide output out of range
    set_cfg(1, 1, 0, 2'b00, 3, 10);  run_frame(0);  // R5 wide pass-through
    set_cfg(0, 1, 0, 2'b00, 5, 40);  run_frame(0);  // R5 narrow pass-through
    set_cfg(1, 0, 1, 2'b00, 1, 1);   run_frame(0);  // R6 idle
    set_cfg(1, 1, 1, 2'b00, 1, 2);   run_frame(0);  // R6 idle wins over bypass
    set_cfg(0, 0, 0, 2'b01, 9, 9);   run_frame(0);  // R8 new rate next sample
    set_cfg(0, 0, 0, 2'b10, 9, 9);   run_frame(0);  // R8 rate change again

    for (int f = 0; f < 10; f++) begin
      logic comp, byp, idl;
      int islot, oslot;
      comp = 1'($urandom); byp = ($urandom % 4) == 0; idl = ($urandom % 6) == 0;
      if (byp) begin
        islot = $urandom % 20; oslot = islot + 1 + ($urandom % 10);
      end else begin
        islot = $urandom % 64; oslot = $urandom % 64;
      end
      set_cfg(comp, byp, idl, 2'($urandom % 3), islot, oslot);
      run_frame(($urandom % 3) == 0);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule